// File: doc/BRIEF.md
# Custom-Format Half-Word Floating-Point Multiplier

This block multiplies two 16-bit floating-point numbers and returns the product in the same 16-bit format one clock cycle later. A word holds the sign in bit 15, a 5-bit biased exponent in bits 14:10 and a 10-bit fraction in bits 9:0. The exponent bias is 31, so the format covers magnitudes from 2^-30 up to just under 2.0. There are no denormal, infinity or NaN codes. A result too large for the format is clamped to the largest magnitude. A result too small is forced to zero.

The datapath has four parts. The operands are unpacked with the implied leading one. An 11x11 significand multiply runs alongside the sign and exponent arithmetic. The product is normalized and then rounded to nearest, ties to even, from exactly one guard bit, one round bit and one sticky bit. The output is registered, and `out_valid` marks each new result.

Top module: `fpm16_mul`

## Requirements
- R1: A word is {sign[15], exponent[14:10], fraction[9:0]} with bias 31. A nonzero operand has the value (-1)^sign x 1.fraction x 2^(exponent-31). An exponent field of 0 with a nonzero fraction is read as a normal number with the implied one.
- R2: The product sign bit is the XOR of the two operand sign bits. This holds for zero, saturated and flushed results too.
- R3: The unrounded product exponent is exponent_a + exponent_b - 31. When the 22-bit significand product is 2.0 or larger, it is shifted right one place and the exponent rises by one.
- R4: The 10 kept fraction bits are rounded up exactly when guard=1 and at least one of round, sticky or the kept LSB is 1. This is round to nearest, ties to even.
- R5: When rounding carries out of the fraction, the fraction becomes 0 and the exponent rises by one more.
- R6: If either operand has bits 14:0 all zero, the product is a signed zero: {sign, 15'h0000}.
- R7: If the final exponent exceeds 31, the product saturates to {sign, 15'h7FFF}. This includes overflow caused only by rounding.
- R8: If the final exponent is below 1, the product is flushed to {sign, 15'h0000}.
- R9: A product appears with `out_valid`=1 on the clock edge after `in_valid`=1 is sampled. Without `in_valid`, `out_valid` is 0 and `product` keeps its last value.
- R10: Synchronous active-high reset clears `out_valid` and `product` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on op_a/op_b are to be multiplied |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| out_valid | output | 1 | product holds a new result |
| product | output | 16 | Registered product |

## Verification
The bench aims at both exact ties: one where the kept LSB is odd and must round up, and one where it is even and must stay. A design that ignores the LSB, or rounds ties away from zero, moves one of them by one unit in the last place. It also drives a significand product just under 2.0 whose rounding carries out. With exponents of 31 that carry must saturate, and with exponents of 30 it must step the exponent exactly once; a missing renormalization yields a doubled or a wrapped exponent. The underflow edge at a final exponent of exactly 1 against 0, signed zeros, and a long stream of random operands compared with an exact remainder-based model catch off-by-one sticky or bias mistakes.

// File: rtl/fpm16_pkg.sv
package fpm16_pkg;

    localparam int EXP_W    = 5;
    localparam int MAN_W    = 10;
    localparam int WORD_W   = 1 + EXP_W + MAN_W;
    localparam int BIAS     = 31;
    localparam int SIG_W    = MAN_W + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int EXP_X_W  = EXP_W + 3;
    localparam int EXP_TOP  = (1 << EXP_W) - 1;

    typedef struct packed {
        logic             sign;
        logic             is_zero;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } fpm_opnd_t;

    typedef struct packed {
        logic                      sign;
        logic                      is_zero;
        logic signed [EXP_X_W-1:0] exp;
        logic [PROD_W-1:0]         prod;
    } fpm_prod_t;

    function automatic logic [WORD_W-1:0] fpm_pack(input logic s,
                                                  input logic [EXP_W-1:0] e,
                                                  input logic [MAN_W-1:0] m);
        return {s, e, m};
    endfunction

    function automatic logic [WORD_W-1:0] fpm_zero(input logic s);
        return {s, {(WORD_W-1){1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] fpm_max(input logic s);
        return {s, {(WORD_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/fpm16_unpack.sv
module fpm16_unpack
    import fpm16_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fpm_opnd_t         opnd_o
);

    always_comb begin
        opnd_o.sign    = word_i[WORD_W-1];
        opnd_o.exp     = word_i[WORD_W-2 -: EXP_W];
        opnd_o.sig     = {1'b1, word_i[MAN_W-1:0]};
        opnd_o.is_zero = (word_i[WORD_W-2:0] == '0);
    end

endmodule

// File: rtl/fpm16_sigmul.sv
module fpm16_sigmul
    import fpm16_pkg::*;
(
    input  fpm_opnd_t lhs_i,
    input  fpm_opnd_t rhs_i,
    output fpm_prod_t prod_o
);

    localparam logic signed [EXP_X_W-1:0] BIAS_X = EXP_X_W'(BIAS);

    logic signed [EXP_X_W-1:0] ea_x;
    logic signed [EXP_X_W-1:0] eb_x;

    always_comb begin
        ea_x           = {{(EXP_X_W-EXP_W){1'b0}}, lhs_i.exp};
        eb_x           = {{(EXP_X_W-EXP_W){1'b0}}, rhs_i.exp};
        prod_o.sign    = lhs_i.sign ^ rhs_i.sign;
        prod_o.is_zero = lhs_i.is_zero | rhs_i.is_zero;
        prod_o.exp     = ea_x + eb_x - BIAS_X;
        prod_o.prod    = PROD_W'(lhs_i.sig) * PROD_W'(rhs_i.sig);
    end

endmodule

// File: rtl/fpm16_round.sv
module fpm16_round
    import fpm16_pkg::*;
(
    input  fpm_prod_t         prod_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int G_POS = PROD_W - 2 - MAN_W;
    localparam int R_POS = G_POS - 1;
    localparam logic signed [EXP_X_W-1:0] EXP_HI_X = EXP_X_W'(EXP_TOP);
    localparam logic signed [EXP_X_W-1:0] EXP_LO_X = EXP_X_W'(1);

    logic                      hi;
    logic [PROD_W-1:0]         shifted;
    logic [MAN_W-1:0]          keep;
    logic                      g_bit;
    logic                      r_bit;
    logic                      s_bit;
    logic                      inc;
    logic [MAN_W:0]            rounded;
    logic [1:0]                bump;
    logic signed [EXP_X_W-1:0] exp_f;

    always_comb begin
        hi      = prod_i.prod[PROD_W-1];
        shifted = hi ? prod_i.prod : (prod_i.prod << 1);
        keep    = shifted[PROD_W-2 -: MAN_W];
        g_bit   = shifted[G_POS];
        r_bit   = shifted[R_POS];
        s_bit   = |shifted[R_POS-1:0];
        inc     = g_bit & (r_bit | s_bit | keep[0]);
        rounded = {1'b0, keep} + {{MAN_W{1'b0}}, inc};
        bump    = {1'b0, hi} + {1'b0, rounded[MAN_W]};
        exp_f   = prod_i.exp + $signed({{(EXP_X_W-2){1'b0}}, bump});

        if (prod_i.is_zero)
            word_o = fpm_zero(prod_i.sign);
        else if (exp_f > EXP_HI_X)
            word_o = fpm_max(prod_i.sign);
        else if (exp_f < EXP_LO_X)
            word_o = fpm_zero(prod_i.sign);
        else
            word_o = fpm_pack(prod_i.sign, exp_f[EXP_W-1:0], rounded[MAN_W-1:0]);
    end

endmodule

// File: rtl/fpm16_mul.sv
module fpm16_mul
    import fpm16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] product
);

    localparam int N_OPS = 2;

    logic [WORD_W-1:0] ops  [N_OPS];
    fpm_opnd_t         opnd [N_OPS];
    fpm_prod_t         raw;
    logic [WORD_W-1:0] result;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_unpack
        fpm16_unpack unpack_i (
            .word_i (ops[gi]),
            .opnd_o (opnd[gi])
        );
    end

    fpm16_sigmul sigmul_i (
        .lhs_i  (opnd[0]),
        .rhs_i  (opnd[1]),
        .prod_o (raw)
    );

    fpm16_round round_i (
        .prod_i (raw),
        .word_o (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                product <= result;
        end
    end

endmodule

// File: rtl/fpm16_mul_chk.sv
module fpm16_mul_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic        out_valid,
    input logic [15:0] product
);

    logic [5:0] exp_sum;
    assign exp_sum = {1'b0, op_a[14:10]} + {1'b0, op_b[14:10]};

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(product)));

    // R2
    sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> product[15] == $past(op_a[15] ^ op_b[15]));

    // R6
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_a[14:0] == 15'h0 || op_b[14:0] == 15'h0))
        |=> product[14:0] == 15'h0);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && exp_sum > 6'd62) |=> product[14:0] == 15'h7FFF);

    // R8
    underflow_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && exp_sum <= 6'd29) |=> product[14:0] == 15'h0);

endmodule

bind fpm16_mul fpm16_mul_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/fpm16_mul_tb.sv
`timescale 1ns/1ps
module fpm16_mul_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = 16'h0;
    logic [15:0] op_b = 16'h0;
    logic        out_valid;
    logic [15:0] product;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] last_exp = 16'h0;

    always #4 clk = ~clk;

    fpm16_mul dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .product   (product)
    );

    // Exact model: nearest-even from the full remainder.
    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b);
        logic s;
        longint p;
        longint q;
        longint rem;
        longint half;
        int e;
        int sh;
        s = a[15] ^ b[15];
        if (a[14:0] == 15'h0 || b[14:0] == 15'h0) return {s, 15'h0};
        p  = longint'(1024 + a[9:0]) * longint'(1024 + b[9:0]);
        e  = int'(a[14:10]) + int'(b[14:10]) - 31;
        sh = 10;
        if (p >= (64'd1 << 21)) begin
            sh = 11;
            e  = e + 1;
        end
        q    = p >> sh;
        rem  = p - (q << sh);
        half = longint'(1) << (sh - 1);
        if (rem > half || (rem == half && q[0])) q = q + 1;
        if (q == 2048) begin
            q = 1024;
            e = e + 1;
        end
        if (e > 31) return {s, 15'h7FFF};
        if (e < 1)  return {s, 15'h0};
        return {s, 5'(e), 10'(q - 1024)};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] a, input logic [15:0] b, input string req);
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        in_valid = 1'b1;
        exp_q.push_back(model(a, b));
        tag_q.push_back(req);
        last_exp = model(a, b);
    endtask

    task automatic send_known(input logic [15:0] a, input logic [15:0] b,
                              input logic [15:0] want, input string req);
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        in_valid = 1'b1;
        exp_q.push_back(want);
        tag_q.push_back(req);
        last_exp = want;
    endtask

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        #1;
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected out_valid", 1'b1 ? 16'h1 : 16'h0, 16'h0);
            end else begin
                check(tag_q.pop_front(), product, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R10 out_valid after reset", {15'h0, out_valid}, 16'h0);
        check("R10 product after reset", product, 16'h0);

        // Hand-worked vectors
        send_known(16'h7C00, 16'h7C00, 16'h7C00, "R1 1.0*1.0");
        send_known(16'h7A00, 16'h7A00, 16'h7880, "R3 0.75*0.75");
        send_known(16'hFA00, 16'h7A00, 16'hF880, "R2 sign xor");
        send_known(16'hFA00, 16'hFA00, 16'h7880, "R2 neg*neg");
        send_known(16'h7C01, 16'h7E00, 16'h7E02, "R4 tie odd rounds up");
        send_known(16'h7C03, 16'h7E00, 16'h7E04, "R4 tie even stays");
        send_known(16'h7C01, 16'h7C01, 16'h7C02, "R4 below half truncates");
        send_known(16'h79A8, 16'h79A8, 16'h7800, "R5 rounding carry renormalizes");
        send_known(16'h7DA8, 16'h7DA8, 16'h7FFF, "R7 rounding carry overflows");
        send_known(16'h7FFF, 16'hFFFF, 16'hFFFF, "R7 saturate negative");
        send_known(16'h0000, 16'h7C00, 16'h0000, "R6 zero operand");
        send_known(16'h8000, 16'h7C00, 16'h8000, "R6 signed zero");
        send_known(16'h7A00, 16'h0000, 16'h0000, "R6 zero second operand");
        send_known(16'h0400, 16'h7C00, 16'h0400, "R8 exponent exactly 1 kept");
        send_known(16'h0400, 16'hF800, 16'h8000, "R8 exponent 0 flushed");
        send_known(16'h0001, 16'h7C00, 16'h0000, "R1 R8 exp0 nonzero fraction");
        send_known(16'h7E00, 16'h7E00, 16'h7FFF, "R3 R7 product above 2 saturates");
        send_known(16'h7A00, 16'h7E00, 16'h7C80, "R3 normalize shift");

        // Random stream checked against the exact model
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (i % 2 == 0) begin
                ra[14:10] = 5'(20 + ($urandom % 12));
                rb[14:10] = 5'(20 + ($urandom % 12));
            end
            send(ra, rb, "R4 random");
            if (i % 7 == 3) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end

        @(negedge clk);
        in_valid = 1'b0;
        op_a     = 16'h7C00;
        op_b     = 16'h7C00;
        repeat (3) @(negedge clk);
        #2;
        check("R9 out_valid low when idle", {15'h0, out_valid}, 16'h0);
        check("R9 product holds when idle", product, last_exp);
        check("R9 scoreboard drained", 16'(exp_q.size()), 16'h0);

        rst = 1'b1;
        @(negedge clk);
        #2;
        check("R10 product after late reset", product, 16'h0);
        rst = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule